// File: doc/BRIEF.md
# I/O Register Space Decoder

This block is the register file and address decoder that sits beside an 8-bit processor core and answers its peripheral-register accesses. The core presents one command per cycle: a port read or write with a short I/O address, a load or store with a 9-bit data-space address, or a single-bit set, clear or test. The decoder maps each command onto a small set of registers: three general-purpose storage registers and one peripheral status register whose flags are raised by a peripheral input and dropped by writing a one.

The short I/O view and the data-space view reach the same low registers. A data-space address equals the I/O address plus 0x20. Data addresses from 0x60 up form an extended window that only loads and stores can reach. Bit operations reach only the lowest 32 I/O addresses. A bit set aimed at the status register clears just the one named flag. Any other pending flag is left alone.

Reads are combinational from the register state. Writes land on the next rising clock edge.

Top module: `io_space`

Register map (default parameters): general register A at I/O 0x05 (data 0x25), status at I/O 0x0B (data 0x2B), general register B at I/O 0x2A (data 0x4A), general register C at data 0x100 (extended window only). Every other address is reserved.

Command encoding on `cmd_i`: 0 idle, 1 port read, 2 port write, 3 load, 4 store, 5 bit set, 6 bit clear, 7 bit test.

## Requirements
- R1: While `rst_ni` is low, all four registers are zero, and they read back as zero after reset is released.
- R2: A port read (1) or port write (2) with I/O address a < 0x40 reaches the register mapped at a. Write data appears on the next rising edge. Read data appears on `rdata_o` in the same cycle.
- R3: A load (3) or store (4) at data address a+0x20 reaches the same register as I/O address a, for every a below 0x40.
- R4: The register at data address 0x100 is reached only by loads and stores. A port command with address 0x40 or higher changes no register and reads zero.
- R5: At any reserved address, including data addresses below 0x20, a write changes no register and a read returns zero.
- R6: A port write or store to the status register clears each flag whose written bit is one and leaves each flag whose written bit is zero unchanged.
- R7: Each bit of `flag_set_i` high at a clock edge sets that status flag. If the same flag is cleared in the same cycle, it ends up set.
- R8: Bit set (5) or bit clear (6) with `bit_idx_i`=k on a general register at an I/O address below 0x20 changes only bit k.
- R9: Bit set on the status register clears only flag k. Bit clear on the status register changes nothing. All other flags are kept.
- R10: Bit test (7) drives `bit_val_o` in the same cycle with bit k of the register at an I/O address below 0x20. A bit command aimed at I/O address 0x20 or higher changes nothing and tests as zero.
- R11: `rdata_o` is zero for every command other than a read or load. `bit_val_o` is zero for every command other than bit test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command code |
| addr_i | input | 9 | I/O address (port and bit commands) or data address (load and store) |
| bit_idx_i | input | 3 | Bit index for bit commands |
| wdata_i | input | 8 | Write data |
| flag_set_i | input | 8 | Peripheral flag-set pulses for the status register |
| rdata_o | output | 8 | Read data |
| bit_val_o | output | 1 | Bit test result |

## Verification
The bench builds the block with its default parameters: an 8-bit data width, a 9-bit data address, a 6-bit I/O address and a 5-bit bit-operation address. With a 9-bit data address, all 512 data addresses can be swept in full. Every port address from 0x00 to 0x7F is also swept, which includes the out-of-range half. Every bit command is swept over I/O addresses 0x00 to 0x3F and all eight bit indices. The status register is refilled before each access, so every clear-on-one and set-wins interaction stays visible at the read port.

// File: rtl/io_space_pkg.sv
package io_space_pkg;
  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_IO_RD   = 3'd1,
    CMD_IO_WR   = 3'd2,
    CMD_DS_RD   = 3'd3,
    CMD_DS_WR   = 3'd4,
    CMD_BIT_SET = 3'd5,
    CMD_BIT_CLR = 3'd6,
    CMD_BIT_TST = 3'd7
  } cmd_e;

  localparam int unsigned NUM_REG  = 4;
  localparam int unsigned IDX_GP_A = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_GP_B = 2;
  localparam int unsigned IDX_GP_C = 3;
endpackage

// File: rtl/io_addr_dec.sv
module io_addr_dec
  import io_space_pkg::*;
#(
  parameter int unsigned AW        = 9,
  parameter int unsigned IO_AW     = 6,
  parameter int unsigned BIT_AW    = 5,
  parameter int unsigned DS_OFS    = 32,
  parameter int unsigned GP_A_IO   = 5,
  parameter int unsigned STAT_IO   = 11,
  parameter int unsigned GP_B_IO   = 42,
  parameter int unsigned GP_C_DS   = 256
) (
  input  logic [2:0]         cmd_i,
  input  logic [AW-1:0]      addr_i,
  output logic [NUM_REG-1:0] sel_o,
  output logic               rd_o,
  output logic               wr_o,
  output logic               bset_o,
  output logic               bclr_o,
  output logic               btst_o
);
  localparam int unsigned IO_SPAN  = 2 ** IO_AW;
  localparam int unsigned BIT_SPAN = 2 ** BIT_AW;
  localparam int unsigned EXT_BASE = DS_OFS + IO_SPAN;

  logic [AW-1:0] ds_a;
  logic          in_rng;
  logic          is_ds;
  cmd_e          cmd;

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    ds_a   = addr_i + AW'(DS_OFS);
    in_rng = 1'b0;
    is_ds  = 1'b0;
    unique case (cmd)
      CMD_IO_RD, CMD_IO_WR:
        in_rng = 32'(addr_i) < IO_SPAN;
      CMD_DS_RD, CMD_DS_WR: begin
        ds_a   = addr_i;
        in_rng = 1'b1;
        is_ds  = 1'b1;
      end
      CMD_BIT_SET, CMD_BIT_CLR, CMD_BIT_TST:
        in_rng = 32'(addr_i) < BIT_SPAN;
      default: in_rng = 1'b0;
    endcase
  end

  always_comb begin
    sel_o           = '0;
    sel_o[IDX_GP_A] = in_rng && (ds_a == AW'(GP_A_IO + DS_OFS));
    sel_o[IDX_STAT] = in_rng && (ds_a == AW'(STAT_IO + DS_OFS));
    sel_o[IDX_GP_B] = in_rng && (ds_a == AW'(GP_B_IO + DS_OFS));
    // extended window: loads and stores only
    sel_o[IDX_GP_C] = in_rng && is_ds && (32'(ds_a) >= EXT_BASE) &&
                      (ds_a == AW'(GP_C_DS));
  end

  assign rd_o   = (cmd == CMD_IO_RD) || (cmd == CMD_DS_RD);
  assign wr_o   = (cmd == CMD_IO_WR) || (cmd == CMD_DS_WR);
  assign bset_o = (cmd == CMD_BIT_SET);
  assign bclr_o = (cmd == CMD_BIT_CLR);
  assign btst_o = (cmd == CMD_BIT_TST);
endmodule

// File: rtl/io_gp_reg.sv
module io_gp_reg #(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          bset_i,
  input  logic          bclr_i,
  input  logic [BW-1:0] bidx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] bmask;
  assign bmask = DW'(1) << bidx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             q_o <= '0;
    else if (sel_i && wr_i)   q_o <= wdata_i;
    else if (sel_i && bset_i) q_o <= q_o | bmask;
    else if (sel_i && bclr_i) q_o <= q_o & ~bmask;
  end
endmodule

// File: rtl/io_w1c_reg.sv
module io_w1c_reg #(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          bset_i,
  input  logic [BW-1:0] bidx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] clr_mask;

  // bit set writes a one to a single flag only; bit clear writes zero -> no-op
  always_comb begin
    clr_mask = '0;
    if (sel_i && wr_i)        clr_mask = wdata_i;
    else if (sel_i && bset_i) clr_mask = DW'(1) << bidx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | set_i;  // set wins
  end
endmodule

// File: rtl/io_space.sv
module io_space
  import io_space_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 9,
  parameter int unsigned IO_AW   = 6,
  parameter int unsigned BIT_AW  = 5,
  parameter int unsigned DS_OFS  = 32,
  parameter int unsigned GP_A_IO = 5,
  parameter int unsigned STAT_IO = 11,
  parameter int unsigned GP_B_IO = 42,
  parameter int unsigned GP_C_DS = 256,
  localparam int unsigned BW     = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    cmd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] bit_idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] flag_set_i,
  output logic [DW-1:0] rdata_o,
  output logic          bit_val_o
);
  logic [NUM_REG-1:0] sel;
  logic               rd, wr, bset, bclr, btst;
  logic [DW-1:0]      reg_q [NUM_REG];
  logic [DW-1:0]      hit_q;

  io_addr_dec #(
    .AW(AW), .IO_AW(IO_AW), .BIT_AW(BIT_AW), .DS_OFS(DS_OFS),
    .GP_A_IO(GP_A_IO), .STAT_IO(STAT_IO), .GP_B_IO(GP_B_IO), .GP_C_DS(GP_C_DS)
  ) u_dec (
    .cmd_i (cmd_i),
    .addr_i(addr_i),
    .sel_o (sel),
    .rd_o  (rd),
    .wr_o  (wr),
    .bset_o(bset),
    .bclr_o(bclr),
    .btst_o(btst)
  );

  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    if (k == IDX_STAT) begin : g_stat
      io_w1c_reg #(.DW(DW)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel[k]),
        .wr_i   (wr),
        .bset_i (bset),
        .bidx_i (bit_idx_i),
        .wdata_i(wdata_i),
        .set_i  (flag_set_i),
        .q_o    (reg_q[k])
      );
    end else begin : g_gp
      io_gp_reg #(.DW(DW)) u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (sel[k]),
        .wr_i   (wr),
        .bset_i (bset),
        .bclr_i (bclr),
        .bidx_i (bit_idx_i),
        .wdata_i(wdata_i),
        .q_o    (reg_q[k])
      );
    end
  end

  always_comb begin
    hit_q = '0;
    for (int k = 0; k < NUM_REG; k++) begin
      if (sel[k]) hit_q = hit_q | reg_q[k];
    end
  end

  assign rdata_o   = rd   ? hit_q : '0;
  assign bit_val_o = btst ? hit_q[bit_idx_i] : 1'b0;
endmodule

// File: rtl/io_space_chk.sv
module io_space_chk
  import io_space_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    cmd_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] flag_set_i,
  input logic [DW-1:0] rdata_o,
  input logic          bit_val_o,
  input logic [DW-1:0] gp_a_q,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] gp_b_q,
  input logic [DW-1:0] gp_c_q
);
  logic is_bitop, is_rd, quiet;
  assign is_bitop = (cmd_i == CMD_BIT_SET) || (cmd_i == CMD_BIT_CLR);
  assign is_rd    = (cmd_i == CMD_IO_RD) || (cmd_i == CMD_DS_RD);
  assign quiet    = (flag_set_i == '0);

  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_i != '0) |=> ((stat_q & $past(flag_set_i)) == $past(flag_set_i))); // R7

  AST_STAT_RISE_ONLY_BY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(flag_set_i)) == '0)); // R9

  AST_BITOP_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_bitop |=> ($countones(gp_a_q ^ $past(gp_a_q)) <= 1 &&
                  $countones(gp_b_q ^ $past(gp_b_q)) <= 1)); // R8

  AST_IO_HIGH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_IO_WR && 32'(addr_i) >= 64 && quiet) |=>
      ($stable(gp_a_q) && $stable(stat_q) && $stable(gp_b_q) && $stable(gp_c_q))); // R4

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NOP && quiet) |=>
      ($stable(gp_a_q) && $stable(stat_q) && $stable(gp_b_q) && $stable(gp_c_q))); // R5

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_rd |-> (rdata_o == '0)); // R11

  AST_BITVAL_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i != CMD_BIT_TST) |-> !bit_val_o); // R11
endmodule

bind io_space io_space_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_i     (cmd_i),
  .addr_i    (addr_i),
  .flag_set_i(flag_set_i),
  .rdata_o   (rdata_o),
  .bit_val_o (bit_val_o),
  .gp_a_q    (reg_q[0]),
  .stat_q    (reg_q[1]),
  .gp_b_q    (reg_q[2]),
  .gp_c_q    (reg_q[3])
);

// File: tb/io_space_test.sv
module io_space_test;
  import io_space_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic [8:0] addr_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] flag_set_i = '0;
  logic [7:0] rdata_o;
  logic       bit_val_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [4];

  always #5 clk_i = ~clk_i;

  io_space uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .addr_i(addr_i),
    .bit_idx_i(bit_idx_i), .wdata_i(wdata_i), .flag_set_i(flag_set_i),
    .rdata_o(rdata_o), .bit_val_o(bit_val_o)
  );

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // map: A io 0x05, STAT io 0x0B, B io 0x2A, C data 0x100
  function automatic int ds_tgt(int a);
    case (a)
      'h25:    return 0;
      'h2B:    return 1;
      'h4A:    return 2;
      'h100:   return 3;
      default: return 4;
    endcase
  endfunction
  function automatic int io_tgt(int a);
    return (a < 'h40) ? ds_tgt(a + 'h20) : 4;
  endfunction
  function automatic int tgt_for(int c, int a);
    case (c)
      1, 2:    return io_tgt(a);
      3, 4:    return ds_tgt(a);
      5, 6, 7: return (a < 'h20) ? io_tgt(a) : 4;
      default: return 4;
    endcase
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic op(int c, int a, int b, int w, int fs, string tag);
    int t;
    int exp_rd;
    int exp_bv;
    t = tgt_for(c, a);
    exp_rd = ((c == 1 || c == 3) && t < 4) ? int'(m[t]) : 0;
    exp_bv = (c == 7 && t < 4) ? int'(m[t][b]) : 0;
    @(negedge clk_i);
    cmd_i = 3'(c); addr_i = 9'(a); bit_idx_i = 3'(b);
    wdata_i = 8'(w); flag_set_i = 8'(fs);
    #1;
    chk(tag, $sformatf("rdata cmd=%0d addr=%0h", c, a), int'(rdata_o), exp_rd);
    chk(tag, $sformatf("bitval cmd=%0d addr=%0h bit=%0d", c, a, b), int'(bit_val_o), exp_bv);
    @(posedge clk_i);
    if (t < 4) begin
      case (c)
        2, 4: if (t == 1) m[1] = m[1] & ~8'(w); else m[t] = 8'(w);
        5:    if (t == 1) m[1] = m[1] & ~(8'd1 << b); else m[t] = m[t] | (8'd1 << b);
        6:    if (t != 1) m[t] = m[t] & ~(8'd1 << b);
        default: ;
      endcase
    end
    m[1] = m[1] | 8'(fs);
    #1;
    cmd_i = 3'd0; flag_set_i = '0;
  endtask

  task automatic verify_all(string tag);
    op(3, 'h25, 0, 0, 0, tag);
    op(3, 'h2B, 0, 0, 0, tag);
    op(3, 'h4A, 0, 0, 0, tag);
    op(3, 'h100, 0, 0, 0, tag);
  endtask

  initial begin
    foreach (m[i]) m[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    verify_all("R1");

    // data-space sweep over all 512 addresses
    for (int a = 0; a < 512; a++) begin
      int t = ds_tgt(a);
      string tg = (t == 4) ? "R5" : (t == 1) ? "R6" : "R3";
      op(0, 0, 0, 0, 'hFF, "R7");
      op(3, a, 0, 0, 0, tg);
      op(4, a, 0, (a * 37 + 11) & 'hFF, 0, "R11");
      verify_all(tg);
    end

    // port sweep including out-of-range half
    for (int a = 0; a < 128; a++) begin
      int t = io_tgt(a);
      string tg = (t != 4) ? "R2" : (a >= 'h40) ? "R4" : "R5";
      op(0, 0, 0, 0, 'h5A ^ a, "R7");
      op(1, a, 0, 0, 0, tg);
      op(2, a, 0, (a * 53 + 7) & 'hFF, 0, tg);
      verify_all(tg);
    end

    // bit command sweep
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 8; b++) begin
        int t = tgt_for(5, a);
        string tg = (a >= 'h20) ? "R10" : (t == 1) ? "R9" : "R8";
        op(0, 0, 0, 0, 'hFF, "R7");
        op(7, a, b, 0, 0, "R10");
        op(5, a, b, 0, 0, tg);
        op(7, a, b, 0, 0, "R10");
        op(6, a, b, 0, 0, tg);
        op(7, a, b, 0, 0, "R10");
        if (t < 4 || a == 'h2A) verify_all(tg);
      end
    end

    // set wins over clear in the same cycle
    op(0, 0, 0, 0, 'hFF, "R7");
    op(4, 'h2B, 0, 'hFF, 'h81, "R7");
    verify_all("R7");
    op(0, 0, 0, 0, 'hFF, "R7");
    op(5, 'h0B, 3, 0, 'h08, "R7");
    op(2, 'h0B, 0, 'h0F, 'h01, "R6");
    verify_all("R7");

    // asynchronous reset mid-run
    op(2, 'h05, 0, 'hA5, 'h3C, "R2");
    @(negedge clk_i) rst_ni = 1'b0;
    #2;
    foreach (m[i]) m[i] = '0;
    @(negedge clk_i) rst_ni = 1'b1;
    verify_all("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule